// File: doc/BRIEF.md
# Bouncing up/down modulo-4 sequencer

This block produces a repeating triangle sequence on a small count output. It counts upward from zero to its top value and keeps that value for one extra clock while its direction flips. It then counts downward to zero, keeps zero for one extra clock while the direction flips back, and starts over. With the default 2-bit count the output runs 0,1,2,3,3,2,1,0,0,1,... and repeats every 8 clocks.

There are no control inputs apart from clock and reset. The step enable of the counter is decoded from the present count and direction. The counter advances at every interior value, and also at an end value when the direction already points away from that end. The direction register goes through a hold/complement multiplexer, so it changes only in the clocks where the counter is stalled. Both outputs come straight from registers.

Top module: `bounce_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count_o` becomes 0 and `dir_up_o` becomes 1 (1 = counting up, 0 = counting down) after that edge.
- R2: When `dir_up_o` is 1 and `count_o` is below its top value (all ones), the next edge raises `count_o` by exactly one and leaves `dir_up_o` at 1.
- R3: When `dir_up_o` is 1 and `count_o` is at its top value, the next edge keeps `count_o` at the top value and clears `dir_up_o` to 0.
- R4: When `dir_up_o` is 0 and `count_o` is above 0, the next edge lowers `count_o` by exactly one and leaves `dir_up_o` at 0.
- R5: When `dir_up_o` is 0 and `count_o` is 0, the next edge keeps `count_o` at 0 and sets `dir_up_o` to 1.
- R6: `dir_up_o` changes only on an edge where `count_o` does not change. The counter never steps and turns in the same clock.
- R7: Out of reset, `count_o` repeats with a period of 2·2^WIDTH clocks (8 for WIDTH=2). Each step changes it by at most one, and it never wraps between 0 and the top value.
- R8: A reset asserted mid-sequence, including during a stall clock at either end, overrides the step and turn logic and restores the R1 state on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| count_o | output | WIDTH | Registered count value |
| dir_up_o | output | 1 | Registered direction, 1 = up, 0 = down |

## Verification
Two functions meet in the same clock here. At each end value the counter stall and the direction flip must happen on one edge, and a reset can land on that very edge. The bench runs the sequence freely through many periods so that every stall/flip edge is visited in both directions. It then asserts reset at each of the eight phases of the period, including both stall clocks. After every edge it compares both outputs with a behavioural model and confirms that reset wins over the pending flip. Separately from the model, it checks that the direction never moves on an edge where the count moves, and that the count matches its own value one period earlier.

// File: rtl/bounce_pkg.sv
package bounce_pkg;

  // Direction encoding shared by the direction register and the decoder.
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

endpackage

// File: rtl/bounce_step_decode.sv
module bounce_step_decode #(
  parameter int WIDTH = 2
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             dir_up_i,
  output logic             step_en_o
);

  localparam int LEVELS = 1 << WIDTH;

  logic [LEVELS-1:0] level_hit;
  logic              interior;

  // One-hot decode of the present count value.
  genvar gi;
  generate
    for (gi = 0; gi < LEVELS; gi++) begin : g_level
      assign level_hit[gi] = (count_i == WIDTH'(gi));
    end
  endgenerate

  // Interior values always step; end values step only when heading inward.
  always_comb begin
    interior = 1'b0;
    for (int i = 1; i < LEVELS - 1; i++) begin
      interior = interior | level_hit[i];
    end
  end

  assign step_en_o = interior
                   | (level_hit[LEVELS-1] & ~dir_up_i)
                   | (level_hit[0]        &  dir_up_i);

endmodule

// File: rtl/bounce_dir_reg.sv
module bounce_dir_reg
  import bounce_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step_en_i,
  output logic dir_up_o
);

  dir_e dir_q;
  dir_e dir_d;

  // Hold while stepping, complement while stalled.
  always_comb begin
    if (step_en_i) begin
      dir_d = dir_q;
    end else begin
      dir_d = (dir_q == DIR_UP) ? DIR_DOWN : DIR_UP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_UP;
    end else begin
      dir_q <= dir_d;
    end
  end

  assign dir_up_o = (dir_q == DIR_UP);

endmodule

// File: rtl/bounce_count_reg.sv
module bounce_count_reg #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en_i,
  input  logic             dir_up_i,
  output logic [WIDTH-1:0] count_o
);

  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_d;

  always_comb begin
    count_d = count_q;
    if (step_en_i) begin
      if (dir_up_i) begin
        count_d = count_q + WIDTH'(1);
      end else begin
        count_d = count_q - WIDTH'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/bounce_seq.sv
module bounce_seq #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] count_o,
  output logic             dir_up_o
);

  logic             step_en;
  logic [WIDTH-1:0] count_q;
  logic             dir_up_q;

  bounce_step_decode #(.WIDTH(WIDTH)) dec_i (
    .count_i   (count_q),
    .dir_up_i  (dir_up_q),
    .step_en_o (step_en)
  );

  bounce_count_reg #(.WIDTH(WIDTH)) cnt_i (
    .clk       (clk),
    .rst       (rst),
    .step_en_i (step_en),
    .dir_up_i  (dir_up_q),
    .count_o   (count_q)
  );

  bounce_dir_reg dir_i (
    .clk       (clk),
    .rst       (rst),
    .step_en_i (step_en),
    .dir_up_o  (dir_up_q)
  );

  assign count_o  = count_q;
  assign dir_up_o = dir_up_q;

endmodule

// File: rtl/bounce_seq_chk.sv
module bounce_seq_chk #(
  parameter int WIDTH = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] count_o,
  input logic             dir_up_o
);

  localparam logic [WIDTH-1:0] TOP = '1;

  logic [WIDTH:0] cnt_wide;
  assign cnt_wide = {1'b0, count_o};

  // R1 / R8: the edge after reset leaves zero, heading up
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count_o == '0) && dir_up_o);

  // R2: upward step below the top
  a_r2_up_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dir_up_o) && ($past(count_o) != TOP))
      |-> (cnt_wide == {1'b0, $past(count_o)} + 1'b1) && dir_up_o);

  // R3: stall and turn at the top
  a_r3_top_turn: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dir_up_o) && ($past(count_o) == TOP))
      |-> (count_o == TOP) && !dir_up_o);

  // R4: downward step above zero
  a_r4_down_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dir_up_o) && ($past(count_o) != '0))
      |-> (cnt_wide + 1'b1 == {1'b0, $past(count_o)}) && !dir_up_o);

  // R5: stall and turn at zero
  a_r5_bottom_turn: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dir_up_o) && ($past(count_o) == '0))
      |-> (count_o == '0) && dir_up_o);

  // R6: no turn on an edge where the count moves
  a_r6_turn_only_stalled: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (count_o != $past(count_o))) |-> $stable(dir_up_o));

  // R7: single-unit moves, never a wrap
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((cnt_wide == {1'b0, $past(count_o)})
                  || (cnt_wide == {1'b0, $past(count_o)} + 1'b1)
                  || (cnt_wide + 1'b1 == {1'b0, $past(count_o)})));

endmodule

bind bounce_seq bounce_seq_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .count_o  (count_o),
  .dir_up_o (dir_up_o)
);

// File: tb/bounce_seq_tb.sv
module bounce_seq_tb_top;

  localparam int WIDTH  = 2;
  localparam int TOPV   = (1 << WIDTH) - 1;
  localparam int PERIOD = 2 * (1 << WIDTH);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [WIDTH-1:0] count_o;
  logic             dir_up_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bounce_seq #(.WIDTH(WIDTH)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .count_o  (count_o),
    .dir_up_o (dir_up_o)
  );

  // Behavioural reference, advanced on every rising edge.
  int    ref_cnt = 0;
  bit    ref_up  = 1'b1;
  bit    ref_ok  = 1'b0;
  bit    running = 1'b0;
  bit    after_rst = 1'b0;
  string tag = "R1";

  always @(posedge clk) begin
    cycles <= cycles + 1;
    ref_ok <= 1'b1;
    after_rst <= rst;
    if (rst) begin
      tag     <= running ? "R8" : "R1";
      ref_cnt <= 0;
      ref_up  <= 1'b1;
    end else begin
      running <= 1'b1;
      if (ref_up && ref_cnt < TOPV) begin
        tag <= "R2"; ref_cnt <= ref_cnt + 1;
      end else if (ref_up) begin
        tag <= "R3"; ref_up <= 1'b0;
      end else if (ref_cnt > 0) begin
        tag <= "R4"; ref_cnt <= ref_cnt - 1;
      end else begin
        tag <= "R5"; ref_up <= 1'b1;
      end
    end
  end

  // Output-only checks at the falling edge.
  int hist[$];
  int last_cnt = 0;
  bit last_dir = 1'b1;

  always @(negedge clk) begin
    if (ref_ok && !done) begin
      checks++;
      if (int'(count_o) != ref_cnt || dir_up_o != ref_up) begin
        errors++;
        $display("FAIL %s: count=%0d dir_up=%0d expected count=%0d dir_up=%0d",
                 tag, count_o, dir_up_o, ref_cnt, ref_up);
      end
      if (after_rst) begin
        hist.delete();
      end else begin
        // R6: direction steady whenever the count moved
        if (int'(count_o) != last_cnt) begin
          checks++;
          if (dir_up_o != last_dir) begin
            errors++;
            $display("FAIL R6: dir_up=%0d expected %0d on a counting edge",
                     dir_up_o, last_dir);
          end
        end
      end
      hist.push_back(int'(count_o));
      // R7: periodicity against the value one period back
      if (hist.size() > PERIOD) begin
        checks++;
        if (hist[hist.size()-1] != hist[hist.size()-1-PERIOD]) begin
          errors++;
          $display("FAIL R7: count=%0d expected %0d (one period earlier)",
                   hist[hist.size()-1], hist[hist.size()-1-PERIOD]);
        end
        void'(hist.pop_front());
      end
      last_cnt = int'(count_o);
      last_dir = dir_up_o;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Watchdog.
  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Free run through many periods: R2..R5 and R7.
    repeat (20 * PERIOD) @(negedge clk);
    // R8: reset at every phase of the period, both stall clocks included.
    for (int ph = 0; ph < PERIOD; ph++) begin
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      repeat (ph) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      repeat (3 * PERIOD) @(negedge clk);
    end
    @(negedge clk);
    finish_run();
  end

endmodule